// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Offset Unit

This unit holds the two threshold offsets that a FIFO flag generator compares against the fill level. One offset sets the almost-empty threshold and the other sets the almost-full threshold. The two are independent, so each flag can be placed at any depth. When master reset is applied, the unit loads both offsets with a default value and selects a programming method. The level of the load-select pin during that reset decides both the default and the method.

After reset, software or a neighbouring controller can rewrite the offsets in the write clock domain. In parallel mode a whole value is taken from the data input bus. In serial mode one bit at a time is shifted in from a serial input. In either mode, both offsets can be read back in the read clock domain onto the output bus. A partial reset rewinds the load and readback sequences but keeps the offsets and the selected method. The FIFO storage, its pointers and the flag comparison are outside this unit.

Top module: `ofs_unit`

## Requirements
- R1: A master reset (`mrst` high at a `wclk`/`rclk` edge) with `ld_n` low loads 127 into both offsets, selects parallel programming (`serial_mode` = 0) and clears `dout` to zero.
- R2: A master reset with `ld_n` high loads 1023 into both offsets and selects serial programming (`serial_mode` = 1).
- R3: In parallel mode, each `wclk` edge with `wen_n` = 0 and `ld_n` = 0 copies `din[OFS_W-1:0]` into one offset. Successive loads alternate between targets, almost-empty first and then almost-full.
- R4: In parallel mode, a write with `ld_n` high and any serial-enable activity leave both offsets unchanged.
- R5: In serial mode, each `wclk` edge with `sen_n` = 0 and `ld_n` = 0 shifts `si` in. The first OFS_W bits fill the almost-empty offset, least significant bit first, and the next OFS_W bits fill the almost-full offset. After 2·OFS_W bits the next bit starts the almost-empty offset again.
- R6: In serial mode, parallel writes (`wen_n` = 0, `ld_n` = 0) leave both offsets unchanged.
- R7: Each `rclk` edge with `ren_n` = 0 and `ld_n` = 0 drives one offset, zero-extended, onto `dout`. Successive reads alternate almost-empty first and then almost-full. Without such a read, `dout` holds its value.
- R8: Readback works the same in serial mode as in parallel mode.
- R9: A partial reset (`prst` high) keeps both offsets, the method and `dout`. It returns the parallel target, the serial bit position and the readback target to almost-empty, and no load or read takes effect in that cycle.
- R10: A readback and a parallel load of the same offset in the same cycle return the value from before the load.
- R11: A master reset takes precedence over a simultaneous partial reset, write or serial shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock (loads, reset sampling) |
| rclk | input | 1 | Read-side clock (readback) |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ld_n | input | 1 | Offset access select, active low; picks the default at master reset |
| wen_n | input | 1 | Write enable, active low (parallel load) |
| sen_n | input | 1 | Serial enable, active low (serial load) |
| ren_n | input | 1 | Read enable, active low (readback) |
| si | input | 1 | Serial data bit |
| din | input | DATA_W | Parallel data bus; the low OFS_W bits are used |
| dout | output | DATA_W | Readback bus, offset zero-extended |
| serial_mode | output | 1 | 1 = serial programming selected, 0 = parallel |
| ofs_empty | output | OFS_W | Almost-empty threshold offset |
| ofs_full | output | OFS_W | Almost-full threshold offset |

## Verification
A parallel load and a readback can hit the same offset in the same cycle. The bench provokes this by clearing both sequence positions with a partial reset and then asserting `wen_n`, `ren_n` and `ld_n` together on one edge. It judges the result by requiring `dout` to show the old almost-empty value while `ofs_empty` takes the new one. A second collision, a master reset arriving together with a partial reset, a write and a serial shift, is judged by requiring only the default values to appear. A behavioural reference model is compared against all outputs on every clock.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic {
        TGT_EMPTY = 1'b0,
        TGT_FULL  = 1'b1
    } ofs_tgt_e;

    typedef enum logic {
        PGM_PARALLEL = 1'b0,
        PGM_SERIAL   = 1'b1
    } pgm_mode_e;

    typedef struct packed {
        logic     par_we;
        logic     ser_sh;
        ofs_tgt_e tgt;
    } ofs_wr_cmd_t;

    function automatic ofs_tgt_e next_tgt(input ofs_tgt_e t);
        return (t == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
    endfunction

    function automatic pgm_mode_e mode_from_sel(input logic sel_hi);
        return sel_hi ? PGM_SERIAL : PGM_PARALLEL;
    endfunction

endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
    import ofs_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic        clk,
    input  logic        mrst,
    input  logic        prst,
    input  logic        ld_n,
    input  logic        wen_n,
    input  logic        sen_n,
    output pgm_mode_e   mode,
    output ofs_wr_cmd_t cmd
);
    localparam int BITS  = 2 * OFS_W;
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] SPLIT = CNT_W'(OFS_W);

    ofs_tgt_e         par_tgt;
    logic [CNT_W-1:0] bit_pos;
    logic             init_done = 1'b0;

    always_comb begin
        cmd.par_we = !mrst && !prst && (mode == PGM_PARALLEL) && !wen_n && !ld_n;
        cmd.ser_sh = !mrst && !prst && (mode == PGM_SERIAL) && !sen_n && !ld_n;
        if (mode == PGM_SERIAL)
            cmd.tgt = (bit_pos >= SPLIT) ? TGT_FULL : TGT_EMPTY;
        else
            cmd.tgt = par_tgt;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode      <= mode_from_sel(ld_n);
            par_tgt   <= TGT_EMPTY;
            bit_pos   <= '0;
            init_done <= 1'b1;
        end else if (prst) begin
            par_tgt <= TGT_EMPTY;
            bit_pos <= '0;
        end else begin
            if (cmd.par_we)
                par_tgt <= next_tgt(par_tgt);
            if (cmd.ser_sh)
                bit_pos <= (bit_pos == LAST) ? '0 : bit_pos + 1'b1;
        end
    end

    // R5: serial position never leaves the 2*OFS_W window
    assert_bitpos_range_R5: assert property (@(posedge clk) disable iff (mrst || !init_done)
        bit_pos <= LAST);

    // R9: method survives everything except master reset
    assert_mode_held_R9: assert property (@(posedge clk) disable iff (mrst || !init_done)
        1'b1 |=> $stable(mode));

    // R9: partial reset rewinds the serial position and parallel target
    assert_prst_rewind_R9: assert property (@(posedge clk) disable iff (mrst || !init_done)
        prst |=> (bit_pos == '0) && (par_tgt == TGT_EMPTY));

    // R4 / R6: only one load path can be live at a time
    assert_one_path_R6: assert property (@(posedge clk) disable iff (mrst || !init_done)
        !(cmd.par_we && cmd.ser_sh));

endmodule

// File: rtl/ofs_slot.sv
module ofs_slot
    import ofs_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [OFS_W-1:0] def_val,
    input  ofs_wr_cmd_t      cmd,
    input  logic [OFS_W-1:0] par_val,
    input  logic             si,
    output logic [OFS_W-1:0] val
);
    localparam ofs_tgt_e MY_TGT = (IDX == 0) ? TGT_EMPTY : TGT_FULL;

    logic hit;
    logic init_done = 1'b0;

    assign hit = (cmd.tgt == MY_TGT) && (cmd.par_we || cmd.ser_sh);

    always_ff @(posedge clk) begin
        if (mrst) begin
            val       <= def_val;
            init_done <= 1'b1;
        end else if (hit) begin
            if (cmd.par_we)
                val <= par_val;
            else
                val <= {si, val[OFS_W-1:1]};
        end
    end

    // R4 / R6: an offset moves only when a load is aimed at it
    assert_slot_idle_R4: assert property (@(posedge clk) disable iff (mrst || !init_done)
        !hit |=> $stable(val));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 14,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld_n,
    input  logic              ren_n,
    input  logic [OFS_W-1:0]  ofs_empty,
    input  logic [OFS_W-1:0]  ofs_full,
    output logic [DATA_W-1:0] dout
);
    ofs_tgt_e rd_tgt;
    logic     strobe;
    logic     init_done = 1'b0;

    assign strobe = !ren_n && !ld_n;

    always_ff @(posedge clk) begin
        if (mrst) begin
            dout      <= '0;
            rd_tgt    <= TGT_EMPTY;
            init_done <= 1'b1;
        end else if (prst) begin
            rd_tgt <= TGT_EMPTY;
        end else if (strobe) begin
            dout   <= DATA_W'((rd_tgt == TGT_FULL) ? ofs_full : ofs_empty);
            rd_tgt <= next_tgt(rd_tgt);
        end
    end

    // R7: bus holds without a read strobe
    assert_dout_hold_R7: assert property (@(posedge clk) disable iff (mrst || !init_done)
        (!strobe || prst) |=> $stable(dout));

    // R7: readback never drives bits above the offset width
    assert_dout_zext_R7: assert property (@(posedge clk) disable iff (mrst || !init_done)
        (dout >> OFS_W) == '0);

    // R9: partial reset restarts readback at the almost-empty offset
    assert_prst_rd_R9: assert property (@(posedge clk) disable iff (mrst || !init_done)
        prst |=> rd_tgt == TGT_EMPTY);

endmodule

// File: rtl/ofs_unit.sv
module ofs_unit
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 14,
    parameter int DATA_W  = 18,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic              sen_n,
    input  logic              ren_n,
    input  logic              si,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              serial_mode,
    output logic [OFS_W-1:0]  ofs_empty,
    output logic [OFS_W-1:0]  ofs_full
);
    localparam int NUM_OFS = 2;
    localparam logic [OFS_W-1:0] DEF_PAR_V = OFS_W'(DEF_PAR);
    localparam logic [OFS_W-1:0] DEF_SER_V = OFS_W'(DEF_SER);

    pgm_mode_e        mode;
    ofs_wr_cmd_t      cmd;
    logic [OFS_W-1:0] def_val;
    logic [OFS_W-1:0] slot_val [NUM_OFS];
    logic             init_done = 1'b0;

    assign def_val     = ld_n ? DEF_SER_V : DEF_PAR_V;
    assign serial_mode = (mode == PGM_SERIAL);
    assign ofs_empty   = slot_val[0];
    assign ofs_full    = slot_val[1];

    generate
        if (DATA_W > OFS_W) begin : g_spare
            logic unused_din_hi;
            assign unused_din_hi = ^din[DATA_W-1:OFS_W];
        end
    endgenerate

    ofs_wr_seq #(.OFS_W(OFS_W)) u_seq (
        .clk   (wclk),
        .mrst  (mrst),
        .prst  (prst),
        .ld_n  (ld_n),
        .wen_n (wen_n),
        .sen_n (sen_n),
        .mode  (mode),
        .cmd   (cmd)
    );

    generate
        for (genvar i = 0; i < NUM_OFS; i++) begin : g_slot
            ofs_slot #(.OFS_W(OFS_W), .IDX(i)) u_slot (
                .clk     (wclk),
                .mrst    (mrst),
                .def_val (def_val),
                .cmd     (cmd),
                .par_val (din[OFS_W-1:0]),
                .si      (si),
                .val     (slot_val[i])
            );
        end
    endgenerate

    ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
        .clk       (rclk),
        .mrst      (mrst),
        .prst      (prst),
        .ld_n      (ld_n),
        .ren_n     (ren_n),
        .ofs_empty (ofs_empty),
        .ofs_full  (ofs_full),
        .dout      (dout)
    );

    always_ff @(posedge wclk) begin
        if (mrst)
            init_done <= 1'b1;
    end

    // R1 / R2 / R11: the cycle after master reset shows the selected default
    assert_reset_default_R2: assert property (@(posedge wclk) disable iff (mrst || !init_done)
        $past(mrst) |-> (ofs_empty == ($past(ld_n) ? DEF_SER_V : DEF_PAR_V)) &&
                        (ofs_full  == ($past(ld_n) ? DEF_SER_V : DEF_PAR_V)) &&
                        (serial_mode == $past(ld_n)));

    // R9: partial reset leaves both offsets untouched
    assert_prst_keeps_R9: assert property (@(posedge wclk) disable iff (mrst || !init_done)
        prst |=> $stable(ofs_empty) && $stable(ofs_full));

endmodule

// File: tb/tb_ofs_unit.sv
module tb_ofs_unit;
    localparam int W  = 14;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic mrst = 1'b1, prst = 1'b0, ld_n = 1'b0;
    logic wen_n = 1'b1, sen_n = 1'b1, ren_n = 1'b1, si = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          serial_mode;
    logic [W-1:0]  ofs_empty, ofs_full;

    always #10 clk = ~clk;

    ofs_unit #(.OFS_W(W), .DATA_W(DW)) dut (
        .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ld_n(ld_n),
        .wen_n(wen_n), .sen_n(sen_n), .ren_n(ren_n), .si(si), .din(din),
        .dout(dout), .serial_mode(serial_mode),
        .ofs_empty(ofs_empty), .ofs_full(ofs_full)
    );

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit done = 0, started = 0;
    string tag = "R1";

    int m_ae, m_af, m_smode, m_wtog, m_scnt, m_rtog, m_dout;
    localparam int MASK = (1 << W) - 1;

    always @(posedge clk) begin
        if (mrst) begin
            m_smode = ld_n; m_ae = ld_n ? 1023 : 127; m_af = m_ae;
            m_wtog = 0; m_scnt = 0; m_rtog = 0; m_dout = 0; started = 1;
        end else if (prst) begin
            m_wtog = 0; m_scnt = 0; m_rtog = 0;
        end else begin
            if (!ren_n && !ld_n) begin
                m_dout = m_rtog ? m_af : m_ae;
                m_rtog ^= 1;
            end
            if (!m_smode && !wen_n && !ld_n) begin
                if (m_wtog) m_af = int'(din) & MASK; else m_ae = int'(din) & MASK;
                m_wtog ^= 1;
            end
            if (m_smode && !sen_n && !ld_n) begin
                if (m_scnt < W) m_ae = (m_ae >> 1) | (int'(si) << (W - 1));
                else            m_af = (m_af >> 1) | (int'(si) << (W - 1));
                m_scnt = (m_scnt + 1) % (2 * W);
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check(tag, "ofs_empty", int'(ofs_empty), m_ae);
            check(tag, "ofs_full", int'(ofs_full), m_af);
            check(tag, "serial_mode", int'(serial_mode), m_smode);
            check(tag, "dout", int'(dout), m_dout);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic idle();
        ld_n = 1; wen_n = 1; sen_n = 1; ren_n = 1; prst = 0; mrst = 0;
    endtask

    task automatic par_write(int v);
        ld_n = 0; wen_n = 0; din = DW'(v); step(); idle(); step();
    endtask

    task automatic rd_back();
        ld_n = 0; ren_n = 0; step(); idle(); step();
    endtask

    task automatic ser_word(int v);
        for (int i = 0; i < W; i++) begin
            ld_n = 0; sen_n = 0; si = v[i]; step();
        end
        idle();
    endtask

    task automatic pulse_prst();
        idle(); prst = 1; step(); idle(); step();
    endtask

    initial begin
        // R1: master reset with ld_n low
        ld_n = 0; mrst = 1; step(3);
        idle(); step(2);
        check("R1", "direct empty", int'(ofs_empty), 127);
        check("R1", "direct mode", int'(serial_mode), 0);
        check("R1", "direct dout", int'(dout), 0);

        tag = "R3";
        par_write(18'h2ABCD);
        par_write(18'h00123);
        check("R3", "direct empty", int'(ofs_empty), 18'h2ABCD & MASK);
        check("R3", "direct full", int'(ofs_full), 18'h123);
        par_write(5); par_write(9);

        tag = "R4";
        ld_n = 1; wen_n = 0; din = 777; step(3); idle();
        ld_n = 0; sen_n = 0; si = 1; step(3); idle(); step();
        check("R4", "direct empty", int'(ofs_empty), 5);

        tag = "R7";
        rd_back(); check("R7", "direct rd empty", int'(dout), 5);
        rd_back(); check("R7", "direct rd full", int'(dout), 9);
        rd_back();
        ren_n = 0; ld_n = 1; step(3); idle(); step();
        check("R7", "direct hold", int'(dout), 5);

        tag = "R9";
        par_write(11);
        pulse_prst();
        check("R9", "direct keeps empty", int'(ofs_empty), 11);
        par_write(22);
        check("R9", "direct rewind to empty", int'(ofs_empty), 22);
        rd_back(); rd_back();
        pulse_prst();
        rd_back();
        check("R9", "direct rd rewind", int'(dout), 22);

        tag = "R10";
        pulse_prst();
        ld_n = 0; wen_n = 0; ren_n = 0; din = 33; step(); idle(); step();
        check("R10", "direct old value", int'(dout), 22);
        check("R10", "direct new empty", int'(ofs_empty), 33);
        rd_back(); rd_back();
        check("R10", "direct later read", int'(dout), 33);

        tag = "R2";
        ld_n = 1; mrst = 1; step(2); idle(); step();
        check("R2", "direct empty", int'(ofs_empty), 1023);
        check("R2", "direct full", int'(ofs_full), 1023);
        check("R2", "direct mode", int'(serial_mode), 1);

        tag = "R5";
        ser_word(14'h01A5); ser_word(14'h2C3F); step();
        check("R5", "direct empty", int'(ofs_empty), 14'h01A5);
        check("R5", "direct full", int'(ofs_full), 14'h2C3F);
        ser_word(14'h0777); step();
        check("R5", "direct wrap", int'(ofs_empty), 14'h0777);
        ser_word(14'h1001); step();

        tag = "R6";
        par_write(55); par_write(66);
        check("R6", "direct empty", int'(ofs_empty), 14'h0777);

        tag = "R8";
        rd_back(); check("R8", "direct rd empty", int'(dout), 14'h0777);
        rd_back(); check("R8", "direct rd full", int'(dout), 14'h1001);

        tag = "R9";
        for (int i = 0; i < 5; i++) begin
            ld_n = 0; sen_n = 0; si = i[0]; step();
        end
        pulse_prst();
        check("R9", "direct mode kept", int'(serial_mode), 1);
        ser_word(14'h00F0); ser_word(14'h3001); step();
        check("R9", "direct serial rewind", int'(ofs_empty), 14'h00F0);

        tag = "R11";
        mrst = 1; prst = 1; ld_n = 0; wen_n = 0; sen_n = 0; din = 99; step();
        idle(); step();
        check("R11", "direct empty", int'(ofs_empty), 127);
        check("R11", "direct full", int'(ofs_full), 127);
        check("R11", "direct mode", int'(serial_mode), 0);
        check("R11", "direct dout", int'(dout), 0);

        step(2);
        finish_run();
    end
endmodule